// File: doc/BRIEF.md
# Counter Tuning-Word Calculator

This block converts a requested output frequency into the settings that a numerically controlled counter needs. It takes the request and the system clock frequency, both unsigned 32-bit hertz values, and a pin index. It works out a 32-bit control word and a 32-bit tuning word. Low requests use the plain oscillator mode. Requests of 500 kHz and above use the PLL mode. In PLL mode the request is first scaled by powers of two until it lies inside the 4 to 8 MHz input window of the multiplier. Each scaling step moves a 3-bit divider code by one, so that the divider later undoes the scaling.

The tuning word is the binary fraction request / clock, scaled by 2^32. A restoring divider produces it, one quotient bit per clock. The caller pulses `start` with the inputs valid. The block raises `busy` while it works. It then pulses `done` for one cycle, with the results and an error flag stable on the outputs. The outputs hold these values until the next completed job.

Top module: `tune_word_calc`

## Requirements
- R1: A request below 500000 selects oscillator mode, mode code 5'b00100. Any other request selects PLL mode, mode code 5'b00010. The mode code appears in `ctrl_word[30:26]`.
- R2: In PLL mode the divider code starts at 3. While the working frequency is below 4000000 and the code is above 0, the frequency doubles and the code falls by one.
- R3: In PLL mode, while the working frequency is above 8000000 and the code is below 7, the frequency halves (rounding down) and the code rises by one. A value exactly at 4000000 or 8000000 is left unscaled.
- R4: `ctrl_word` holds the divider code in bits 25:23 and the pin index in bits 5:0. In oscillator mode the divider code field is 0. Every other bit is 0.
- R5: `tune_word` equals floor(f * 2^32 / clk_hz), where f is the working frequency after normalisation.
- R6: If `clk_hz` is zero, or f is not less than `clk_hz`, then `err` is 1 and `tune_word` is 0. `ctrl_word` is still formed. Otherwise `err` is 0.
- R7: `busy` is 1 in the cycle after an accepted `start`. `done` is a single-cycle pulse, with `busy` low, in the cycle when the results first appear.
- R8: A `start` pulse while `busy` is 1 is ignored. The job in progress finishes with its own inputs.
- R9: After reset, `busy`, `done`, `err`, `ctrl_word` and `tune_word` are all 0.
- R10: The outputs change only in a cycle where `done` is 1, and they hold between jobs even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job using the current inputs (only accepted when idle) |
| req_hz | input | 32 | Requested output frequency in Hz |
| clk_hz | input | 32 | System clock frequency in Hz |
| pin_sel | input | 6 | Output pin index copied into the control word |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last job had a zero clock or an out-of-range ratio |
| ctrl_word | output | 32 | Mode, divider code and pin index |
| tune_word | output | 32 | Fractional frequency word |

## Verification
The bench targets the mode edge at 499999 against 500000. It also covers the window edges at exactly 4 MHz and 8 MHz, and a very high request that pins the code at 7 while still above the window. A design with an off-by-one comparison would report the wrong mode or an extra shift, and the control word would show it. Error cases include a zero clock, and a request that normalisation pushes above the clock. A divider without a guard would emit a meaningless word there. A second `start` is sent mid-job; a design that restarts would return the second job's result. The 32-step divide is compared against a 64-bit division. A step count off by one would double or halve the word.

// File: rtl/tune_word_calc.sv
module tune_word_calc #(
  parameter int          W         = 32,
  parameter int          PIN_W     = 6,
  parameter logic [31:0] PLL_MIN   = 32'd500000,
  parameter logic [31:0] WIN_LO    = 32'd4000000,
  parameter logic [31:0] WIN_HI    = 32'd8000000,
  parameter logic [4:0]  MODE_OSC  = 5'b00100,
  parameter logic [4:0]  MODE_PLL  = 5'b00010,
  parameter logic [2:0]  CODE_INIT = 3'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     req_hz,
  input  logic [W-1:0]     clk_hz,
  input  logic [PIN_W-1:0] pin_sel,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [W-1:0]     ctrl_word,
  output logic [W-1:0]     tune_word
);
  localparam int CNT_W    = $clog2(W);
  localparam int MODE_LSB = 26;
  localparam int CODE_LSB = 23;

  typedef enum logic [2:0] {S_IDLE, S_NORM, S_CHK, S_DIV, S_FIN} state_t;

  state_t           st;
  logic [W:0]       num;
  logic [W-1:0]     den, quo;
  logic [2:0]       code;
  logic [4:0]       mode;
  logic [PIN_W-1:0] pin_q;
  logic [CNT_W-1:0] cnt;

  logic [W:0]   num2;
  logic         ge;
  logic         go_up, go_dn;
  logic [W-1:0] ctrl_next;

  assign num2  = {num[W-1:0], 1'b0};
  assign ge    = num2 >= {1'b0, den};
  assign go_up = (num < {1'b0, WIN_LO}) && (code != 3'd0);
  assign go_dn = (num > {1'b0, WIN_HI}) && (code != 3'd7);
  assign busy  = (st != S_IDLE) && (st != S_FIN);
  assign done  = (st == S_FIN);

  always_comb begin
    ctrl_next = '0;
    ctrl_next[MODE_LSB +: 5] = mode;
    ctrl_next[CODE_LSB +: 3] = code;
    ctrl_next[PIN_W-1:0]     = pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      num       <= '0;
      den       <= '0;
      quo       <= '0;
      code      <= '0;
      mode      <= '0;
      pin_q     <= '0;
      cnt       <= '0;
      err       <= 1'b0;
      ctrl_word <= '0;
      tune_word <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          num   <= {1'b0, req_hz};
          den   <= clk_hz;
          pin_q <= pin_sel;
          quo   <= '0;
          cnt   <= '0;
          if (req_hz < PLL_MIN) begin
            mode <= MODE_OSC;
            code <= 3'd0;
            st   <= S_CHK;
          end else begin
            mode <= MODE_PLL;
            code <= CODE_INIT;
            st   <= S_NORM;
          end
        end
        S_NORM: begin
          if (go_up) begin
            num  <= num2;
            code <= code - 3'd1;
          end else if (go_dn) begin
            num  <= num >> 1;
            code <= code + 3'd1;
          end else begin
            st <= S_CHK;
          end
        end
        S_CHK: begin
          if (den == '0 || num >= {1'b0, den}) begin
            err       <= 1'b1;
            tune_word <= '0;
            ctrl_word <= ctrl_next;
            st        <= S_FIN;
          end else begin
            st <= S_DIV;
          end
        end
        S_DIV: begin
          num <= ge ? num2 - {1'b0, den} : num2;
          quo <= {quo[W-2:0], ge};
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(W-1)) begin
            err       <= 1'b0;
            tune_word <= {quo[W-2:0], ge};
            ctrl_word <= ctrl_next;
            st        <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module tune_word_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [31:0] ctrl_word,
  input logic [31:0] tune_word
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && !done) |=> busy);
  // R10
  hold_tune_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(tune_word));
  // R10
  hold_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(ctrl_word));
  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> tune_word == 32'd0);
  // R4
  osc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ctrl_word[30:26] == 5'b00100) |-> ctrl_word[25:23] == 3'd0);
  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctrl_word[30:26] == 5'b00100 || ctrl_word[30:26] == 5'b00010));
endmodule

bind tune_word_calc tune_word_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .ctrl_word(ctrl_word), .tune_word(tune_word)
);

// File: tb/tb_tune_word_calc.sv
module tb_tune_word_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_hz = '0, clk_hz = '0;
  logic [5:0]  pin_sel = '0;
  logic        busy, done, err;
  logic [31:0] ctrl_word, tune_word;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tune_word_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_hz(req_hz), .clk_hz(clk_hz),
    .pin_sel(pin_sel), .busy(busy), .done(done), .err(err),
    .ctrl_word(ctrl_word), .tune_word(tune_word)
  );

  localparam int NV = 13;
  localparam logic [69:0] VEC [NV] = '{
    {32'd3579545,    32'd80000000,  6'd23},
    {32'd100000,     32'd80000000,  6'd5},
    {32'd500000,     32'd80000000,  6'd1},
    {32'd499999,     32'd80000000,  6'd2},
    {32'd20000000,   32'd80000000,  6'd7},
    {32'd8000000,    32'd80000000,  6'd8},
    {32'd4000000,    32'd80000000,  6'd9},
    {32'd128000000,  32'd300000000, 6'd10},
    {32'd1000000000, 32'd2000000000,6'd11},
    {32'd600000,     32'd1000000,   6'd12},
    {32'd1000000,    32'd0,         6'd13},
    {32'd300000,     32'd200000,    6'd14},
    {32'd400000,     32'd3000000,   6'd63}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] r, input logic [31:0] s, input logic [5:0] p,
                       output logic [31:0] c, output logic [31:0] t, output logic e);
    longint unsigned n;
    int code;
    logic [4:0] m;
    n = 64'(r);
    if (r < 32'd500000) begin
      m = 5'b00100; code = 0;
    end else begin
      m = 5'b00010; code = 3;
      while (n < 64'd4000000 && code > 0) begin n = n * 2; code--; end
      while (n > 64'd8000000 && code < 7) begin n = n / 2; code++; end
    end
    c = {1'b0, m, code[2:0], 17'b0, p};
    e = (s == 0) || (n >= 64'(s));
    t = e ? 32'd0 : 32'((n << 32) / 64'(s));
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      if (done) return;
      @(negedge clk);
    end
    check(1'b0, "R7 done never seen", 32'(done), 32'd1);
  endtask

  task automatic run_one(input logic [31:0] r, input logic [31:0] s, input logic [5:0] p);
    logic [31:0] ec, et;
    logic ee;
    model(r, s, p, ec, et, ee);
    @(negedge clk);
    req_hz = r; clk_hz = s; pin_sel = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after start", 32'(busy), 32'd1);
    wait_done();
    check(busy == 1'b0, "R7 busy low with done", 32'(busy), 32'd0);
    check(ctrl_word == ec, "R1 R2 R3 R4 ctrl_word", ctrl_word, ec);
    check(tune_word == et, "R5 tune_word", tune_word, et);
    check(err == ee, "R6 err", 32'(err), 32'(ee));
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    logic [31:0] ec, et, hold_c, hold_t;
    logic ee;
    #20;
    check(busy == 0 && done == 0 && err == 0, "R9 reset flags", {busy, done, err}, 32'd0);
    check(ctrl_word == 0, "R9 reset ctrl_word", ctrl_word, 32'd0);
    check(tune_word == 0, "R9 reset tune_word", tune_word, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_one(VEC[i][69:38], VEC[i][37:6], VEC[i][5:0]);

    // R8: a second start while busy must be ignored
    model(32'd3579545, 32'd80000000, 6'd23, ec, et, ee);
    @(negedge clk);
    req_hz = 32'd3579545; clk_hz = 32'd80000000; pin_sel = 6'd23; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    req_hz = 32'd100000; pin_sel = 6'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check(ctrl_word == ec, "R8 ctrl_word ignores mid-job start", ctrl_word, ec);
    check(tune_word == et, "R8 tune_word ignores mid-job start", tune_word, et);
    @(negedge clk);
    check(busy == 1'b0, "R8 no restart after mid-job start", 32'(busy), 32'd0);

    // R10: outputs hold while inputs change without start
    hold_c = ctrl_word; hold_t = tune_word;
    req_hz = 32'd7; clk_hz = 32'd9; pin_sel = 6'd33;
    repeat (6) @(negedge clk);
    check(ctrl_word == hold_c, "R10 ctrl_word holds", ctrl_word, hold_c);
    check(tune_word == hold_t, "R10 tune_word holds", tune_word, hold_t);
    check(done == 1'b0 && busy == 1'b0, "R10 stays idle", {done, busy}, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule